// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gate

This block sits between the free-running source clocks of a clock generator and its output pins. For every output it decides, each cycle, whether the clock runs, is held at logic 0 with the pin driven, or is parked low with the pin released to high impedance. The decision combines four kinds of input:

- a per-output enable;
- two active-low stop pins, one serving the processor-class outputs and one serving the bus-class outputs;
- a software stop bit that acts like the bus-class pin;
- an active-high power-down pin.

Each output carries three more configuration bits:

- a stoppable bit, which decides whether a stop request reaches it;
- a bit choosing driven-low or high impedance while stopped;
- a bit making the same choice while powered down.

The stop pins are brought into each output's own clock domain before use. The gate itself only changes while the source clock is low. A stopped clock therefore always finishes its last high phase in full, and a restarted clock always begins with a full high phase. Power-down is the one exception: it acts asynchronously and silences every output at once. When power-down is released, each output resumes according to its unchanged configuration bits.

Top module: `clk_stop_gate`

## Requirements
- R1: An output whose enable bit is 0 never toggles: its clock is 0 and its output-enable is 1 (driven low).
- R2: A bus-class output with stoppable=1 and stop-drive=0 holds its clock at 0, with output-enable 1, while `pciStopN` is 0.
- R3: An output whose stoppable bit is 0 keeps running regardless of `pciStopN`, `cpuStopN` and `swStop`.
- R4: Class is set by parameter CPU_MASK, where bit i = 1 marks output i as processor-class. Processor-class outputs respond only to `cpuStopN`. Bus-class outputs respond only to `pciStopN` and `swStop`.
- R5: While a stoppable output is stopped, stop-drive bit = 1 sets its output-enable to 0, and stop-drive bit = 0 sets it to 1. The clock is 0 in both cases.
- R6: While `pdIn` is 1, every clock output is 0 at once, with no clock edge needed. Each output-enable equals the inverse of that output's power-down drive bit. The same state holds during reset.
- R7: Setting `swStop` to 1 stops stoppable bus-class outputs exactly as `pciStopN` = 0 does.
- R8: Suppose a stop or start input changes between rising edges P0 and P1 of an output's source clock. The change is sampled by two rising edges and applied at the falling edge after P2. On a stop, the high phase that starts at P2 is the last one. On a start, the first high phase starts at P3.
- R9: After `pdIn` falls, each output returns to the state its unchanged configuration bits select, with the R8 timing counted from the release, and with no register rewrite.
- R10: Whenever an output clock is high, its output-enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset |
| srcClk | input | N_OUT | Free-running source clock, one per output |
| pciStopN | input | 1 | Active-low stop request for bus-class outputs |
| cpuStopN | input | 1 | Active-low stop request for processor-class outputs |
| swStop | input | 1 | Software stop bit, same effect as pciStopN low |
| pdIn | input | 1 | Asynchronous active-high power-down |
| enBits | input | N_OUT | Per-output enable |
| stoppable | input | N_OUT | Per-output: 1 = honours stop requests |
| stopHiZ | input | N_OUT | Per-output: 1 = high impedance while stopped |
| pdHiZ | input | N_OUT | Per-output: 1 = high impedance in power-down |
| clkOut | output | N_OUT | Gated clock per output |
| clkOe | output | N_OUT | Output-enable per output (0 = high impedance) |

## Verification
A stop request and power-down can land in the same clock phase. The asynchronous clear of the gate must then win over the pending falling-edge update. The bench provokes this by raising `pdIn` halfway through a high phase of a running output. It then expects the clock to drop within that phase and the output-enable to follow the power-down bit, not the stop bit. A sweep over every mix of enable, stoppable, stop-drive, both pins and the software bit also covers the case where both stop sources are asserted together. Each output's clock and output-enable are compared against values worked out from its class.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  // Strobes from control to datapath, one set per output
  typedef struct packed {
    logic run;      // clock may run after the next falling edge
    logic drive;    // pin driven when not in power-down
    logic pdAct;    // power-down active in this domain
    logic pdDrive;  // pin driven while in power-down
  } gate_strobe_t;
endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import clk_gate_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter logic [N_OUT-1:0] CPU_MASK = 4'b0011,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     rstN,
  input  logic [N_OUT-1:0]         srcClk,
  input  logic                     pciStopN,
  input  logic                     cpuStopN,
  input  logic                     swStop,
  input  logic                     pdIn,
  input  logic [N_OUT-1:0]         enBits,
  input  logic [N_OUT-1:0]         stoppable,
  input  logic [N_OUT-1:0]         stopHiZ,
  input  logic [N_OUT-1:0]         pdHiZ,
  output gate_strobe_t [N_OUT-1:0] strobes
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [SYNC_STAGES-1:0] IDLE = '1;

  logic pciReqN;
  assign pciReqN = pciStopN & ~swStop;

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    logic [SYNC_STAGES-1:0] pciSync, cpuSync, pdSync;
    logic stopReq, stopped;

    always_ff @(posedge srcClk[i] or negedge rstN) begin
      if (!rstN) begin
        pciSync <= IDLE;
        cpuSync <= IDLE;
      end else begin
        pciSync <= {pciSync[SYNC_STAGES-2:0], pciReqN};
        cpuSync <= {cpuSync[SYNC_STAGES-2:0], cpuStopN};
      end
    end

    always_ff @(posedge srcClk[i] or posedge pdIn or negedge rstN) begin
      if (!rstN)     pdSync <= IDLE;
      else if (pdIn) pdSync <= IDLE;
      else           pdSync <= {pdSync[SYNC_STAGES-2:0], 1'b0};
    end

    if (CPU_MASK[i]) begin : g_cpu
      assign stopReq = ~cpuSync[LAST];
    end else begin : g_bus
      assign stopReq = ~pciSync[LAST];
    end

    assign stopped = stoppable[i] & stopReq;

    always_comb begin
      strobes[i].run     = enBits[i] & ~stopped & ~pdSync[LAST];
      strobes[i].drive   = ~enBits[i] | ~stopped | ~stopHiZ[i];
      strobes[i].pdAct   = pdSync[LAST];
      strobes[i].pdDrive = ~pdHiZ[i];
    end

    // R3
    free_run_chk: assert property (@(posedge srcClk[i]) disable iff (!rstN)
      (!stoppable[i] && enBits[i] && !pdSync[LAST]) |-> strobes[i].run);
  end
endmodule

// File: rtl/cg_datapath.sv
module cg_datapath
  import clk_gate_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic                     rstN,
  input  logic [N_OUT-1:0]         srcClk,
  input  logic                     pdIn,
  input  gate_strobe_t [N_OUT-1:0] strobes,
  output logic [N_OUT-1:0]         clkOut,
  output logic [N_OUT-1:0]         clkOe
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    logic runQ, oeQ;

    // Updates only while the source clock is low, so no partial pulse
    always_ff @(negedge srcClk[i] or negedge rstN or posedge pdIn) begin
      if (!rstN) begin
        runQ <= 1'b0;
        oeQ  <= 1'b1;
      end else if (pdIn) begin
        runQ <= 1'b0;
        oeQ  <= oeQ;
      end else begin
        runQ <= strobes[i].run;
        oeQ  <= strobes[i].drive;
      end
    end

    assign clkOut[i] = srcClk[i] & runQ;
    assign clkOe[i]  = strobes[i].pdAct ? strobes[i].pdDrive : oeQ;

    // R10
    drive_when_run_chk: assert property (@(negedge srcClk[i]) disable iff (!rstN)
      clkOut[i] |-> clkOe[i]);
    // R6
    pd_silent_chk: assert property (@(negedge srcClk[i]) disable iff (!rstN)
      strobes[i].pdAct |-> !clkOut[i]);
    // R8
    stop_at_fall_chk: assert property (@(negedge srcClk[i]) disable iff (!rstN || pdIn)
      !strobes[i].run |=> !runQ);
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_gate_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter logic [N_OUT-1:0] CPU_MASK = 4'b0011
) (
  input  logic             rstN,
  input  logic [N_OUT-1:0] srcClk,
  input  logic             pciStopN,
  input  logic             cpuStopN,
  input  logic             swStop,
  input  logic             pdIn,
  input  logic [N_OUT-1:0] enBits,
  input  logic [N_OUT-1:0] stoppable,
  input  logic [N_OUT-1:0] stopHiZ,
  input  logic [N_OUT-1:0] pdHiZ,
  output logic [N_OUT-1:0] clkOut,
  output logic [N_OUT-1:0] clkOe
);
  gate_strobe_t [N_OUT-1:0] strobes;

  cg_ctrl #(.N_OUT(N_OUT), .CPU_MASK(CPU_MASK), .SYNC_STAGES(2)) u_ctrl (
    .rstN(rstN), .srcClk(srcClk), .pciStopN(pciStopN), .cpuStopN(cpuStopN),
    .swStop(swStop), .pdIn(pdIn), .enBits(enBits), .stoppable(stoppable),
    .stopHiZ(stopHiZ), .pdHiZ(pdHiZ), .strobes(strobes)
  );

  cg_datapath #(.N_OUT(N_OUT)) u_dp (
    .rstN(rstN), .srcClk(srcClk), .pdIn(pdIn), .strobes(strobes),
    .clkOut(clkOut), .clkOe(clkOe)
  );
endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/100ps
module sim_clk_stop_gate;
  localparam int N = 4;
  localparam logic [N-1:0] CPUM = 4'b0011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pciStopN = 1'b1, cpuStopN = 1'b1, swStop = 1'b0, pdIn = 1'b0;
  logic [N-1:0] enBits = '1, stoppable = '0, stopHiZ = '0, pdHiZ = '0;
  logic [N-1:0] clkOut, clkOe, srcClk;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign srcClk = {N{clk}};

  clk_stop_gate #(.N_OUT(N), .CPU_MASK(CPUM)) u0 (
    .rstN(rstN), .srcClk(srcClk), .pciStopN(pciStopN), .cpuStopN(cpuStopN),
    .swStop(swStop), .pdIn(pdIn), .enBits(enBits), .stoppable(stoppable),
    .stopHiZ(stopHiZ), .pdHiZ(pdHiZ), .clkOut(clkOut), .clkOe(clkOe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One rising edge, then 1 ns into the high phase
  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // Reset state (R6): clocks low, pins follow power-down drive bits
    pdHiZ = 4'b0101;
    repeat (3) step();
    check(clkOut == 0, "R6", "reset clkOut", clkOut, 0);
    check(clkOe == 4'b1010, "R6", "reset clkOe", clkOe, 4'b1010);
    pdHiZ = '0;
    rstN = 1'b1;
    repeat (4) step();
    check(clkOut == '1, "R10", "run after reset", clkOut, 4'hf);

    // Sweep every combination, same configuration on all outputs
    for (int k = 0; k < 64; k++) begin
      bit en = k[0], stb = k[1], hz = k[2], pn = k[3], cn = k[4], sw = k[5];
      enBits = {N{en}}; stoppable = {N{stb}}; stopHiZ = {N{hz}};
      pciStopN = pn; cpuStopN = cn; swStop = sw;
      repeat (4) step();
      for (int i = 0; i < N; i++) begin
        bit isCpu = CPUM[i];
        bit req = isCpu ? !cn : (!pn || sw);
        bit stopped = stb && req;
        bit expRun = en && !stopped;
        bit expOe = !en ? 1'b1 : (stopped ? !hz : 1'b1);
        string tag;
        if (!en) tag = "R1";
        else if (!stb) tag = "R3";
        else if (stopped && isCpu) tag = "R4";
        else if (stopped && pn && sw) tag = "R7";
        else if (stopped) tag = hz ? "R5" : "R2";
        else tag = isCpu ? "R4" : "R10";
        check(clkOut[i] == expRun, tag, $sformatf("case %0d out %0d clk", k, i), clkOut[i], expRun);
        check(clkOe[i] == expOe, tag, $sformatf("case %0d out %0d oe", k, i), clkOe[i], expOe);
      end
    end

    // Stop/start edge timing (R8) on bus-class output 2
    enBits = '1; stoppable = '1; stopHiZ = '0; pciStopN = 1'b1; cpuStopN = 1'b1; swStop = 1'b0;
    repeat (4) step();
    pciStopN = 1'b0;                // between P0 and P1
    step(); check(clkOut[2] == 1, "R8", "stop P1 high", clkOut[2], 1);
    step(); check(clkOut[2] == 1, "R8", "stop P2 last high", clkOut[2], 1);
    step(); check(clkOut[2] == 0, "R8", "stop P3 low", clkOut[2], 0);
    check(clkOut[0] == 1, "R4", "cpu output ignores bus stop", clkOut[0], 1);
    pciStopN = 1'b1;
    step(); check(clkOut[2] == 0, "R8", "start P1 low", clkOut[2], 0);
    step(); check(clkOut[2] == 0, "R8", "start P2 low", clkOut[2], 0);
    step(); check(clkOut[2] == 1, "R8", "start P3 high", clkOut[2], 1);

    // Power-down mid high phase, then release (R6, R9)
    enBits = 4'b1110; stoppable = 4'b0001; pdHiZ = 4'b0110;
    repeat (4) step();
    check(clkOut == 4'b1110, "R9", "before pd", clkOut, 4'b1110);
    pciStopN = 1'b0;                // stop request in the same phase
    pdIn = 1'b1;
    #0.3;
    check(clkOut == 0, "R6", "pd immediate clk", clkOut, 0);
    check(clkOe == 4'b1001, "R6", "pd oe", clkOe, 4'b1001);
    pciStopN = 1'b1;
    repeat (3) step();
    check(clkOut == 0, "R6", "pd held", clkOut, 0);
    pdIn = 1'b0;
    step(); check(clkOut == 0, "R9", "release P1", clkOut, 0);
    step(); check(clkOut == 0, "R9", "release P2", clkOut, 0);
    step(); check(clkOut == 4'b1110, "R9", "release P3 resumes", clkOut, 4'b1110);
    check(clkOe == 4'b1111, "R9", "release oe", clkOe, 4'b1111);

    finish_run();
  end
endmodule